// File: doc/BRIEF.md
# Integer ALU with Condition-Set and Shift Operations

This block is the arithmetic and logic unit of a 32-bit load/store processor core. Each cycle it takes two operands, a shift distance, the 6-bit primary opcode and the 6-bit function code of the instruction. It decodes the opcode and function code together into one internal control word, then computes a single 32-bit result plus a signed-overflow flag. Operand B is prepared by the caller. It is either a register value or a 16-bit immediate that has already been sign-extended, so the immediate compare forms use exactly the same datapath as the register forms.

The unit covers add and subtract, each in a trapping and a non-trapping flavour, three bitwise operations, and a load-upper operation. It also covers eight compare-and-set conditions that yield a 0/1 word, and logical or arithmetic shifts. The shift distance comes from either a dedicated field or the low five bits of operand B. Both outputs are registered: they appear one clock after the inputs are presented, and a synchronous active-high reset clears them.

Top module: `rset_alu`

## Requirements
- R1: While `rst` is high at a rising edge, `result` and `ovf` are cleared to 0 at that edge. Otherwise both outputs take, at each rising edge, the value computed from the inputs present just before that edge.
- R2: With `opcode` 0x00, `func` 0x20 and 0x21 give `a + b`, and `func` 0x22 and 0x23 give `a - b`, both modulo 2^32.
- R3: `ovf` is 1 only for `opcode` 0x00 with `func` 0x20 (signed add) or 0x22 (signed subtract), and only when the two's-complement result does not fit in 32 bits. For every other code `ovf` is 0.
- R4: With `opcode` 0x00, `func` 0x24 gives `a & b`, 0x25 gives `a | b` and 0x26 gives `a ^ b`.
- R5: With `opcode` 0x00 and `func` 0x27, the result holds `b[15:0]` in bits 31:16 and zeros in bits 15:0.
- R6: With `opcode` 0x00 and `func` 0x28 to 0x2f, the result is 1 when a condition holds and 0 otherwise. The condition is selected by `func[2:0]`: 0 never, 1 a>b, 2 a==b, 3 a>=b, 4 a<b, 5 a!=b, 6 a<=b, 7 always. The comparisons are signed two's-complement.
- R7: `opcode` 0x18 to 0x1f perform the same compare-and-set as R6, with the condition taken from `opcode[2:0]` and `b` standing for the sign-extended immediate. `func` is ignored.
- R8: With `opcode` 0x00 and `func` 0x00 to 0x03, `a` is shifted by `shamt`. `func[1]` = 1 selects a right shift, and `func[0]` = 1 selects the arithmetic variant.
- R9: `func` 0x04 to 0x07 perform the same four shifts as R8, with the distance taken from `b[4:0]`. Bits 31:5 of `b` have no effect.
- R10: A left arithmetic shift gives exactly the bits of a left logical shift. A right arithmetic shift fills the vacated upper bits with `a[31]`, and a right logical shift fills them with 0.
- R11: `opcode` 0x00 with `func` 0x08 to 0x1f or 0x30 to 0x3f gives result 0 and `ovf` 0. So does any `opcode` other than 0x00 and 0x18 to 0x1f.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 6 | Primary opcode of the instruction |
| func | input | 6 | Function code (used when opcode is 0x00) |
| a | input | 32 | First operand |
| b | input | 32 | Second operand: register value or sign-extended immediate |
| shamt | input | 5 | Shift distance field of the instruction |
| result | output | 32 | Registered result |
| ovf | output | 1 | Registered signed-overflow flag |

## Verification
Both `result` and `ovf` are due exactly one rising edge after their inputs are applied, whatever the operation: one pass through the logic with no internal pipeline. The bench drives each stimulus on a falling edge and waits for the next rising edge. It samples shortly after that edge and compares against a behavioural model evaluated on the same inputs. Inputs stay unchanged until the following falling edge, so no sample can see a half-updated stimulus. The checker's properties likewise relate each output to the inputs of the previous cycle through `$past`.

// File: rtl/rset_alu_pkg.sv
package rset_alu_pkg;

    localparam logic [5:0] OPC_REG      = 6'h00;
    localparam logic [2:0] OPC_SETI_HI  = 3'b011;

    localparam logic [2:0] FN_GRP_SHIFT = 3'b000;
    localparam logic [2:0] FN_GRP_ARITH = 3'b100;
    localparam logic [2:0] FN_GRP_SET   = 3'b101;

    typedef enum logic [2:0] {
        CND_NEVER  = 3'd0,
        CND_GT     = 3'd1,
        CND_EQ     = 3'd2,
        CND_GE     = 3'd3,
        CND_LT     = 3'd4,
        CND_NE     = 3'd5,
        CND_LE     = 3'd6,
        CND_ALWAYS = 3'd7
    } cond_t;

    typedef enum logic [3:0] {
        K_NONE,
        K_ADD,
        K_SUB,
        K_AND,
        K_OR,
        K_XOR,
        K_LHI,
        K_CMP,
        K_SHF
    } kind_t;

    typedef struct packed {
        kind_t kind;
        logic  ovf_en;
        cond_t cond;
        logic  sh_right;
        logic  sh_arith;
        logic  sh_reg;
    } alu_ctl_t;

    localparam alu_ctl_t CTL_IDLE = '{
        kind:     K_NONE,
        ovf_en:   1'b0,
        cond:     CND_NEVER,
        sh_right: 1'b0,
        sh_arith: 1'b0,
        sh_reg:   1'b0
    };

    function automatic logic signed_ovf(input logic sa, input logic sb, input logic sr);
        return (sa == sb) && (sr != sa);
    endfunction

endpackage

// File: rtl/alu_decode.sv
module alu_decode
    import rset_alu_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] func,
    output alu_ctl_t   ctl
);

    always_comb begin
        ctl = CTL_IDLE;
        if (opcode == OPC_REG) begin
            unique case (func[5:3])
                FN_GRP_SHIFT: begin
                    ctl.kind     = K_SHF;
                    ctl.sh_reg   = func[2];
                    ctl.sh_right = func[1];
                    ctl.sh_arith = func[0];
                end
                FN_GRP_ARITH: begin
                    unique case (func[2:0])
                        3'd0: begin ctl.kind = K_ADD; ctl.ovf_en = 1'b1; end
                        3'd1: ctl.kind = K_ADD;
                        3'd2: begin ctl.kind = K_SUB; ctl.ovf_en = 1'b1; end
                        3'd3: ctl.kind = K_SUB;
                        3'd4: ctl.kind = K_AND;
                        3'd5: ctl.kind = K_OR;
                        3'd6: ctl.kind = K_XOR;
                        default: ctl.kind = K_LHI;
                    endcase
                end
                FN_GRP_SET: begin
                    ctl.kind = K_CMP;
                    ctl.cond = cond_t'(func[2:0]);
                end
                default: ctl = CTL_IDLE;
            endcase
        end else if (opcode[5:3] == OPC_SETI_HI) begin
            ctl.kind = K_CMP;
            ctl.cond = cond_t'(opcode[2:0]);
        end
    end

endmodule

// File: rtl/alu_shift.sv
module alu_shift #(
    parameter int W  = 32,
    parameter int SW = $clog2(W)
) (
    input  logic [W-1:0]  din,
    input  logic [SW-1:0] amt,
    input  logic          right,
    input  logic          arith,
    output logic [W-1:0]  dout
);

    function automatic logic [W-1:0] flip(input logic [W-1:0] v);
        logic [W-1:0] r;
        for (int i = 0; i < W; i++) r[i] = v[W-1-i];
        return r;
    endfunction

    logic              fill;
    logic [SW:0][W-1:0] stg;

    assign fill   = right & arith & din[W-1];
    assign stg[0] = right ? din : flip(din);

    for (genvar s = 0; s < SW; s++) begin : g_stage
        localparam int D = 1 << s;
        assign stg[s+1] = amt[s] ? {{D{fill}}, stg[s][W-1:D]} : stg[s];
    end

    assign dout = right ? stg[SW] : flip(stg[SW]);

endmodule

// File: rtl/alu_cmp.sv
module alu_cmp
    import rset_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  cond_t        cond,
    output logic         hit
);

    logic lt, eq;

    assign lt = $signed(a) < $signed(b);
    assign eq = (a == b);

    always_comb begin
        unique case (cond)
            CND_NEVER:  hit = 1'b0;
            CND_GT:     hit = !lt && !eq;
            CND_EQ:     hit = eq;
            CND_GE:     hit = !lt;
            CND_LT:     hit = lt;
            CND_NE:     hit = !eq;
            CND_LE:     hit = lt || eq;
            default:    hit = 1'b1;
        endcase
    end

endmodule

// File: rtl/rset_alu.sv
module rset_alu
    import rset_alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [5:0]                  opcode,
    input  logic [5:0]                  func,
    input  logic [DATA_W-1:0]           a,
    input  logic [DATA_W-1:0]           b,
    input  logic [$clog2(DATA_W)-1:0]   shamt,
    output logic [DATA_W-1:0]           result,
    output logic                        ovf
);

    localparam int SH_W = $clog2(DATA_W);
    localparam int HALF = DATA_W / 2;
    localparam int MSB  = DATA_W - 1;

    alu_ctl_t          ctl;
    logic [DATA_W-1:0] sum, diff, sh_out, res_d;
    logic [SH_W-1:0]   sh_amt;
    logic              cmp_hit, ovf_d;

    alu_decode u_dec (
        .opcode (opcode),
        .func   (func),
        .ctl    (ctl)
    );

    assign sh_amt = ctl.sh_reg ? b[SH_W-1:0] : shamt;

    alu_shift #(.W(DATA_W), .SW(SH_W)) u_shf (
        .din   (a),
        .amt   (sh_amt),
        .right (ctl.sh_right),
        .arith (ctl.sh_arith),
        .dout  (sh_out)
    );

    alu_cmp #(.W(DATA_W)) u_cmp (
        .a    (a),
        .b    (b),
        .cond (ctl.cond),
        .hit  (cmp_hit)
    );

    assign sum  = a + b;
    assign diff = a - b;

    always_comb begin
        res_d = '0;
        ovf_d = 1'b0;
        unique case (ctl.kind)
            K_ADD: begin
                res_d = sum;
                ovf_d = ctl.ovf_en & signed_ovf(a[MSB], b[MSB], sum[MSB]);
            end
            K_SUB: begin
                res_d = diff;
                ovf_d = ctl.ovf_en & signed_ovf(a[MSB], ~b[MSB], diff[MSB]);
            end
            K_AND:   res_d = a & b;
            K_OR:    res_d = a | b;
            K_XOR:   res_d = a ^ b;
            K_LHI:   res_d = {b[HALF-1:0], {(DATA_W-HALF){1'b0}}};
            K_CMP:   res_d = {{(DATA_W-1){1'b0}}, cmp_hit};
            K_SHF:   res_d = sh_out;
            default: res_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            result <= '0;
            ovf    <= 1'b0;
        end else begin
            result <= res_d;
            ovf    <= ovf_d;
        end
    end

endmodule

// File: rtl/rset_alu_chk.sv
module rset_alu_chk #(
    parameter int DATA_W = 32
) (
    input logic                      clk,
    input logic                      rst,
    input logic [5:0]                opcode,
    input logic [5:0]                func,
    input logic [DATA_W-1:0]         a,
    input logic [DATA_W-1:0]         b,
    input logic [$clog2(DATA_W)-1:0] shamt,
    input logic [DATA_W-1:0]         result,
    input logic                      ovf
);

    logic armed = 1'b0;
    always_ff @(posedge clk) if (rst) armed <= 1'b1;

    logic is_reg, is_seti, fn_bad, op_bad;
    assign is_reg  = (opcode == 6'h00);
    assign is_seti = (opcode[5:3] == 3'b011);
    assign fn_bad  = is_reg && (func[5:3] != 3'b000) && (func[5:3] != 3'b100) && (func[5:3] != 3'b101);
    assign op_bad  = !is_reg && !is_seti;

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!armed)
        $past(rst) |-> (result == '0) && !ovf);

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        ovf |-> $past(is_reg && (func == 6'h20 || func == 6'h22)));

    // R2
    wrap_add_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        $past(is_reg && func == 6'h21) |-> result == $past(a) + $past(b));

    // R5
    upper_load_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        $past(is_reg && func == 6'h27) |-> result == {$past(b[DATA_W/2-1:0]), {(DATA_W/2){1'b0}}});

    // R7
    imm_set_bool_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        $past(is_seti) |-> (result[DATA_W-1:1] == '0) && !ovf);

    // R6
    always_true_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        $past(is_reg && func == 6'h2f) |-> result == DATA_W'(1));

    // R6
    never_true_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        $past(is_reg && func == 6'h28) |-> result == '0);

    // R11
    unknown_code_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        $past(fn_bad || op_bad) |-> (result == '0) && !ovf);

endmodule

bind rset_alu rset_alu_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/test_rset_alu.sv
`timescale 1ns/100ps
module test_rset_alu;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  opcode = '0;
    logic [5:0]  func = '0;
    logic [31:0] a = '0;
    logic [31:0] b = '0;
    logic [4:0]  shamt = '0;
    logic [31:0] result;
    logic        ovf;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    rset_alu i_rset_alu (
        .clk    (clk),
        .rst    (rst),
        .opcode (opcode),
        .func   (func),
        .a      (a),
        .b      (b),
        .shamt  (shamt),
        .result (result),
        .ovf    (ovf)
    );

    function automatic bit cond_eval(input int c, input longint sa, input longint sb);
        case (c)
            0: return 1'b0;
            1: return sa > sb;
            2: return sa == sb;
            3: return sa >= sb;
            4: return sa < sb;
            5: return sa != sb;
            6: return sa <= sb;
            default: return 1'b1;
        endcase
    endfunction

    function automatic logic [32:0] model(input logic [5:0] op, input logic [5:0] f,
                                          input logic [31:0] x, input logic [31:0] y,
                                          input logic [4:0] sh);
        longint sx = longint'($signed(x));
        longint sy = longint'($signed(y));
        longint s;
        logic [31:0] r = '0;
        logic o = 1'b0;
        int amt;
        if (op == 6'h00) begin
            amt = f[2] ? int'(y[4:0]) : int'(sh);
            if (f <= 6'h07) begin
                if (!f[1]) r = x << amt;
                else if (f[0]) r = $signed(x) >>> amt;
                else r = x >> amt;
            end else if (f == 6'h20 || f == 6'h21) begin
                r = x + y;
                s = sx + sy;
                o = (f == 6'h20) && (s > 64'sd2147483647 || s < -64'sd2147483648);
            end else if (f == 6'h22 || f == 6'h23) begin
                r = x - y;
                s = sx - sy;
                o = (f == 6'h22) && (s > 64'sd2147483647 || s < -64'sd2147483648);
            end else if (f == 6'h24) r = x & y;
            else if (f == 6'h25) r = x | y;
            else if (f == 6'h26) r = x ^ y;
            else if (f == 6'h27) r = {y[15:0], 16'h0000};
            else if (f >= 6'h28 && f <= 6'h2f) r = {31'd0, cond_eval(int'(f) - 40, sx, sy)};
        end else if (op >= 6'h18 && op <= 6'h1f) begin
            r = {31'd0, cond_eval(int'(op) - 24, sx, sy)};
        end
        return {o, r};
    endfunction

    function automatic string tag_of(input logic [5:0] op, input logic [5:0] f);
        if (op >= 6'h18 && op <= 6'h1f) return "R7";
        if (op != 6'h00) return "R11";
        if (f <= 6'h07) return f[0] ? "R10" : (f[2] ? "R9" : "R8");
        if (f >= 6'h20 && f <= 6'h23) return "R2";
        if (f >= 6'h24 && f <= 6'h26) return "R4";
        if (f == 6'h27) return "R5";
        if (f >= 6'h28 && f <= 6'h2f) return "R6";
        return "R11";
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic [5:0] op, input logic [5:0] f,
                          input logic [31:0] x, input logic [31:0] y, input logic [4:0] sh);
        logic [32:0] e;
        opcode = op; func = f; a = x; b = y; shamt = sh;
        e = model(op, f, x, y, sh);
        @(posedge clk);
        #1;
        check(tag_of(op, f), result, e[31:0]);
        check("R3", {31'd0, ovf}, {31'd0, e[32]});
        @(negedge clk);
    endtask

    function automatic logic [31:0] pick_val();
        case ($urandom_range(0, 7))
            0: return 32'h7fffffff;
            1: return 32'h80000000;
            2: return 32'hffffffff;
            3: return 32'h00000000;
            4: return 32'h00000001;
            default: return $urandom();
        endcase
    endfunction

    initial begin
        // R1: reset clears outputs even with an overflowing add at the inputs
        opcode = 6'h00; func = 6'h20; a = 32'h7fffffff; b = 32'h1;
        repeat (3) @(posedge clk);
        #1;
        check("R1", result, 32'h0);
        check("R1", {31'd0, ovf}, 32'h0);
        @(negedge clk);
        rst = 1'b0;

        // R2 / R3 boundaries
        run_op(6'h00, 6'h20, 32'h7fffffff, 32'h00000001, 5'd0);
        run_op(6'h00, 6'h21, 32'h7fffffff, 32'h00000001, 5'd0);
        run_op(6'h00, 6'h22, 32'h80000000, 32'h00000001, 5'd0);
        run_op(6'h00, 6'h23, 32'h80000000, 32'h00000001, 5'd0);
        run_op(6'h00, 6'h20, 32'hffffffff, 32'h00000001, 5'd0);
        // R4, R5
        run_op(6'h00, 6'h24, 32'hf0f0a5a5, 32'h0ff05a5a, 5'd0);
        run_op(6'h00, 6'h26, 32'hf0f0a5a5, 32'h0ff05a5a, 5'd0);
        run_op(6'h00, 6'h27, 32'h12345678, 32'habcd9876, 5'd0);
        // R6 signed compare: -1 versus 1
        run_op(6'h00, 6'h2c, 32'hffffffff, 32'h00000001, 5'd0);
        run_op(6'h00, 6'h29, 32'hffffffff, 32'h00000001, 5'd0);
        run_op(6'h00, 6'h2e, 32'h00000005, 32'h00000005, 5'd0);
        // R7 immediate compare, func ignored
        run_op(6'h1a, 6'h3f, 32'hffff8000, 32'hffff8000, 5'd0);
        run_op(6'h1f, 6'h00, 32'h0, 32'h0, 5'd0);
        // R8, R9, R10 shifts
        run_op(6'h00, 6'h03, 32'h80000000, 32'h0, 5'd31);
        run_op(6'h00, 6'h02, 32'h80000000, 32'h0, 5'd31);
        run_op(6'h00, 6'h01, 32'hc0000001, 32'h0, 5'd1);
        run_op(6'h00, 6'h07, 32'h90000000, 32'hffffffe3, 5'd17);
        run_op(6'h00, 6'h04, 32'h00000001, 32'h00000020, 5'd4);
        // R11 unrecognised codes
        run_op(6'h00, 6'h10, 32'hffffffff, 32'hffffffff, 5'd3);
        run_op(6'h00, 6'h30, 32'h7fffffff, 32'h00000001, 5'd3);
        run_op(6'h23, 6'h20, 32'h7fffffff, 32'h00000001, 5'd3);

        for (int n = 0; n < 4000; n++) begin
            logic [5:0] op, f;
            case ($urandom_range(0, 4))
                0, 1: begin op = 6'h00; f = 6'($urandom_range(32, 47)); end
                2:    begin op = 6'h00; f = 6'($urandom_range(0, 7)); end
                3:    begin op = 6'(6'h18 + $urandom_range(0, 7)); f = 6'($urandom()); end
                default: begin op = 6'($urandom()); f = 6'($urandom()); end
            endcase
            run_op(op, f, pick_val(), pick_val(), 5'($urandom()));
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule